// File: doc/BRIEF.md
# Multi-Event Circular Readout Buffer

This block sits between the front end that produces compacted events and the host readout path. Each incoming event is a run of data words that arrives over a valid/ready stream and ends with a last-word marker. Words go into a circular data memory. When an event completes, a slot table records where it starts and how long it is. Slots are taken in ring order. A write pointer names the slot the next event will go into. A read pointer names the oldest event that is still waiting. New events can arrive while older ones are being read, and neither side waits for the other.

The host drives three plain commands. A load command makes the oldest waiting event the current event and latches its length into the word-count register in the same step. A skip command drops the oldest waiting event without loading it. Each host read request is answered one cycle later with an acknowledge, a data word and a status code. The status is 0 while words of the current event remain and 2 once that event is used up. The host can also overwrite both slot pointers directly.

One slot of the ring always stays reserved for the event under readout, so at most `N_SLOTS-1` events can wait at the same time. When that limit is reached, or when the data memory holds all the words it can retain, the stream input stops accepting words.

Top module: `evbuf_top`

## Requirements
- R1: After reset, `has_event`=0, `evt_full`=0, `wr_ready`=1, `word_count`=0 and both pointers are 0. A read request is then answered with status 2 and data 0.
- R2: A word is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. The word with `wr_last`=1 completes the event: `wr_ptr` advances by one (mod `N_SLOTS`), and `has_event` is 1 whenever at least one completed event waits.
- R3: The waiting-event count is `wr_ptr - rd_ptr` mod `N_SLOTS`. When it equals `N_SLOTS-1`, `evt_full`=1 and `wr_ready`=0.
- R4: A load command with an event waiting makes that event current. On the next cycle `word_count` equals its length in words and `rd_ptr` has advanced by one.
- R5: A load command with no event waiting sets `word_count` to 0 and clears the current event. Later reads return status 2.
- R6: Each read request gets `rd_ack`=1 on the following cycle. The words of the current event come back in the order they were written, each with status 0. After `word_count` words, every further read returns status 2 and data 0.
- R7: A skip command with an event waiting advances `rd_ptr` by one and leaves `word_count` and the current event unchanged. A skip with no event waiting does nothing. A skip issued in the same cycle as a load is ignored.
- R8: Retained words are those of the current event, of the waiting events and of the event being written. While they fill all `DEPTH` words, `wr_ready`=0. The input becomes ready again once a load releases the old current event. The memory wraps, so an event may cross the end of the address range.
- R9: `ptr_load` overwrites both pointers with `ptr_wr_in` and `ptr_rd_in`. The count, `has_event`, `evt_full` and `wr_ready` then follow from the new values.
- R10: An event completing in the same cycle as a load or skip takes full effect, and the command acts on the state from before that edge. A read request in the same cycle as a load is served from the previous current event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Event word offered |
| wr_ready | output | 1 | Word can be taken (low = busy) |
| wr_data | input | DW | Event data word |
| wr_last | input | 1 | Final word of the event |
| load_next | input | 1 | Load the next waiting event for readout |
| skip | input | 1 | Discard the oldest waiting event |
| rd_req | input | 1 | Host read data cycle |
| rd_ack | output | 1 | Read answer valid |
| rd_data | output | DW | Read word, 0 at end of data |
| rd_status | output | 3 | 0 = valid word, 2 = end of data |
| word_count | output | clog2(DEPTH)+1 | Length of the current event |
| has_event | output | 1 | At least one completed event waiting |
| evt_full | output | 1 | All non-reserved slots hold events |
| ptr_load | input | 1 | Overwrite both slot pointers |
| ptr_wr_in | input | clog2(N_SLOTS) | New write pointer |
| ptr_rd_in | input | clog2(N_SLOTS) | New read pointer |
| wr_ptr | output | clog2(N_SLOTS) | Slot for the next event |
| rd_ptr | output | clog2(N_SLOTS) | Slot of the oldest waiting event |

## Verification
Two things can happen in one clock edge: an event completing on the write side, and a load or skip moving the read side. The bench provokes this by raising the final `wr_last` word in the same cycle as `load_next`, once with the queue empty and once with `skip` and one event waiting. It then judges the outcome from the pointers, `has_event` and `word_count`: the load must see an empty queue, and the skip must drop only the older event. A read request is also issued in the same cycle as a load, and its answer must still come from the previous event. The configuration is small, 4 slots and 16 words, so the slot limit and the memory limit are both reached, and the address wrap is crossed.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  typedef enum logic [2:0] {
    RS_VALID = 3'd0,
    RS_EOD   = 3'd2
  } rd_status_t;
endpackage

// File: rtl/evbuf_writer.sv
module evbuf_writer #(
  parameter int AW = 8,
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          last,
  output logic [LW-1:0] waddr,
  output logic [LW-1:0] ev_start,
  output logic [LW-1:0] ev_len,
  output logic          commit
);
  // waddr carries one extra bit so that full and empty occupancy differ
  assign commit = fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr    <= '0;
      ev_start <= '0;
      ev_len   <= '0;
    end else if (fire) begin
      waddr <= waddr + LW'(1);
      if (last) begin
        ev_start <= waddr + LW'(1);
        ev_len   <= '0;
      end else begin
        ev_len <= ev_len + LW'(1);
      end
    end
  end

  AST_EVENT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fire && last |=> ev_len == '0 && ev_start == waddr); // R2
endmodule

// File: rtl/evbuf_slot_table.sv
module evbuf_slot_table #(
  parameter int N_SLOTS = 64,
  parameter int LW = 9,
  localparam int SW = $clog2(N_SLOTS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] widx,
  input  logic [LW-1:0] wstart,
  input  logic [LW-1:0] wlen,
  input  logic [SW-1:0] ridx,
  output logic [LW-1:0] rstart,
  output logic [LW-1:0] rlen
);
  logic [LW-1:0] start_q [N_SLOTS];
  logic [LW-1:0] len_q   [N_SLOTS];

  always_ff @(posedge clk) begin
    if (we) begin
      start_q[widx] <= wstart;
      len_q[widx]   <= wlen;
    end
  end

  // combinational lookup: the head length is available in the load cycle
  assign rstart = start_q[ridx];
  assign rlen   = len_q[ridx];
endmodule

// File: rtl/evbuf_data_mem.sv
module evbuf_data_mem #(
  parameter int DW = 16,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    if (re) rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/evbuf_top.sv
module evbuf_top
  import evbuf_pkg::*;
#(
  parameter int N_SLOTS = 64,
  parameter int DEPTH = 256,
  parameter int DW = 16,
  localparam int SW = $clog2(N_SLOTS),
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          load_next,
  input  logic          skip,
  input  logic          rd_req,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    rd_status,
  output logic [LW-1:0] word_count,
  output logic          has_event,
  output logic          evt_full,
  input  logic          ptr_load,
  input  logic [SW-1:0] ptr_wr_in,
  input  logic [SW-1:0] ptr_rd_in,
  output logic [SW-1:0] wr_ptr,
  output logic [SW-1:0] rd_ptr
);
  logic [LW-1:0] waddr, ev_start, ev_len;
  logic          commit, fire;
  logic [LW-1:0] head_start, head_len;
  logic [SW-1:0] count;
  logic          q_empty;
  logic          cur_valid;
  logic [LW-1:0] cur_start, offset;
  logic [LW-1:0] oldest, used;
  logic          mem_full, rd_hit, hit_q;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] mem_rdata;
  rd_status_t    status_q;

  // occupancy: one slot stays reserved, so the difference never wraps to zero
  assign count     = wr_ptr - rd_ptr;
  assign q_empty   = (count == '0);
  assign has_event = !q_empty;
  assign evt_full  = (count == SW'(N_SLOTS - 1));

  // oldest word that must survive: current event, else head, else open event
  always_comb begin
    if (cur_valid)    oldest = cur_start;
    else if (q_empty) oldest = ev_start;
    else              oldest = head_start;
  end
  assign used     = waddr - oldest;
  assign mem_full = (used == LW'(DEPTH));
  assign wr_ready = !evt_full && !mem_full;
  assign fire     = wr_valid && wr_ready;

  evbuf_writer #(.AW(AW)) u_writer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .last(wr_last),
    .waddr(waddr), .ev_start(ev_start), .ev_len(ev_len), .commit(commit)
  );

  evbuf_slot_table #(.N_SLOTS(N_SLOTS), .LW(LW)) u_slots (
    .clk(clk), .we(commit), .widx(wr_ptr), .wstart(ev_start),
    .wlen(ev_len + LW'(1)), .ridx(rd_ptr), .rstart(head_start), .rlen(head_len)
  );

  assign rd_hit  = cur_valid && (offset < word_count);
  assign rd_addr = cur_start[AW-1:0] + offset[AW-1:0];

  evbuf_data_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(fire), .waddr(waddr[AW-1:0]), .wdata(wr_data),
    .re(rd_req && rd_hit), .raddr(rd_addr), .rdata(mem_rdata)
  );

  // slot pointers: host overwrite wins, load beats skip
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (ptr_load) begin
      wr_ptr <= ptr_wr_in;
      rd_ptr <= ptr_rd_in;
    end else begin
      if (commit) wr_ptr <= wr_ptr + SW'(1);
      if (!q_empty && (load_next || skip)) rd_ptr <= rd_ptr + SW'(1);
    end
  end

  // current event and word-count register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_valid  <= 1'b0;
      cur_start  <= '0;
      word_count <= '0;
      offset     <= '0;
    end else if (load_next) begin
      offset <= '0;
      if (!q_empty) begin
        cur_valid  <= 1'b1;
        cur_start  <= head_start;
        word_count <= head_len;
      end else begin
        cur_valid  <= 1'b0;
        word_count <= '0;
      end
    end else if (rd_req && rd_hit) begin
      offset <= offset + LW'(1);
    end
  end

  // read answer, one cycle after the request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack   <= 1'b0;
      hit_q    <= 1'b0;
      status_q <= RS_EOD;
    end else begin
      rd_ack <= rd_req;
      if (rd_req) begin
        hit_q    <= rd_hit;
        status_q <= rd_hit ? RS_VALID : RS_EOD;
      end
    end
  end
  assign rd_data   = hit_q ? mem_rdata : '0;
  assign rd_status = status_q;

  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack); // R6
  AST_LOAD_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    load_next && !q_empty |=> cur_valid && offset == '0); // R4
  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load_next && q_empty |=> !cur_valid && word_count == '0); // R5
  AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    skip && !load_next && !q_empty && !ptr_load |=> rd_ptr == $past(rd_ptr) + SW'(1)); // R7
  AST_COMMIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !load_next && !skip && !ptr_load |=> count == $past(count) + SW'(1)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= LW'(DEPTH)); // R8
endmodule

// File: tb/evbuf_top_test.sv
module evbuf_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int DP = 16;
  localparam int DW = 16;
  localparam int SW = $clog2(NS);
  localparam int LW = $clog2(DP) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, load_next = 1'b0, skip = 1'b0;
  logic rd_req = 1'b0, ptr_load = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] ptr_wr_in = '0, ptr_rd_in = '0;
  logic wr_ready, rd_ack, has_event, evt_full;
  logic [DW-1:0] rd_data;
  logic [2:0] rd_status;
  logic [LW-1:0] word_count;
  logic [SW-1:0] wr_ptr, rd_ptr;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evbuf_top #(.N_SLOTS(NS), .DEPTH(DP), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .load_next(load_next), .skip(skip),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .rd_status(rd_status),
    .word_count(word_count), .has_event(has_event), .evt_full(evt_full),
    .ptr_load(ptr_load), .ptr_wr_in(ptr_wr_in), .ptr_rd_in(ptr_rd_in),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int id, input int w);
    return DW'(id * 16 + w);
  endfunction

  // pushes words first..first+n-1 of event id; marks last on the final one if fin
  task automatic put_words(input int id, input int first, input int n, input bit fin);
    for (int w = first; w < first + n; w++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = word_of(id, w);
      wr_last  = fin && (w == first + n - 1);
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic cmd(input bit ld, input bit sk);
    @(negedge clk);
    load_next = ld;
    skip = sk;
    @(negedge clk);
    load_next = 1'b0;
    skip = 1'b0;
  endtask

  task automatic rd(input string req, input int exp_data, input int exp_st);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(req, "ack", int'(rd_ack), 1);
    chk(req, "data", int'(rd_data), exp_data);
    chk(req, "status", int'(rd_status), exp_st);
  endtask

  task automatic ptrs(input int w, input int r);
    @(negedge clk);
    ptr_load = 1'b1;
    ptr_wr_in = SW'(w);
    ptr_rd_in = SW'(r);
    @(negedge clk);
    ptr_load = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "has_event", int'(has_event), 0);
    chk("R1", "evt_full", int'(evt_full), 0);
    chk("R1", "wr_ready", int'(wr_ready), 1);
    chk("R1", "word_count", int'(word_count), 0);
    chk("R1", "wr_ptr", int'(wr_ptr), 0);
    chk("R1", "rd_ptr", int'(rd_ptr), 0);
    rd("R1", 0, 2);

    // R2/R3: fill the three free slots with events of length 1, 2, 3
    for (int e = 0; e < 3; e++) begin
      put_words(e, 0, e + 1, 1'b1);
      chk("R2", "wr_ptr", int'(wr_ptr), e + 1);
      chk("R2", "has_event", int'(has_event), 1);
    end
    chk("R3", "evt_full", int'(evt_full), 1);
    chk("R3", "wr_ready", int'(wr_ready), 0);

    // R4/R6: load event 0 and read past its end
    cmd(1'b1, 1'b0);
    chk("R4", "word_count", int'(word_count), 1);
    chk("R4", "rd_ptr", int'(rd_ptr), 1);
    chk("R3", "evt_full", int'(evt_full), 0);
    rd("R6", int'(word_of(0, 0)), 0);
    rd("R6", 0, 2);

    // R7: skip event 1, current unchanged
    cmd(1'b0, 1'b1);
    chk("R7", "rd_ptr", int'(rd_ptr), 2);
    chk("R7", "word_count", int'(word_count), 1);
    rd("R7", 0, 2);

    // R4/R6: event 2, three words in order
    cmd(1'b1, 1'b0);
    chk("R4", "word_count", int'(word_count), 3);
    chk("R4", "has_event", int'(has_event), 0);
    for (int w = 0; w < 3; w++) rd("R6", int'(word_of(2, w)), 0);
    rd("R6", 0, 2);

    // R5: load with nothing waiting; R7: skip on empty is ignored
    cmd(1'b1, 1'b0);
    chk("R5", "word_count", int'(word_count), 0);
    rd("R5", 0, 2);
    cmd(1'b0, 1'b1);
    chk("R7", "rd_ptr", int'(rd_ptr), 3);

    // R8: fill the data memory (6 + 6 + 4 words), release by loading
    put_words(3, 0, 6, 1'b1);
    put_words(4, 0, 6, 1'b1);
    put_words(5, 0, 4, 1'b0);
    chk("R8", "wr_ready full memory", int'(wr_ready), 0);
    cmd(1'b1, 1'b0);
    chk("R8", "word_count", int'(word_count), 6);
    chk("R8", "wr_ready still held", int'(wr_ready), 0);
    cmd(1'b1, 1'b0);
    chk("R8", "wr_ready released", int'(wr_ready), 1);
    put_words(5, 4, 2, 1'b1);
    for (int w = 0; w < 6; w++) rd("R8", int'(word_of(4, w)), 0);
    cmd(1'b1, 1'b0);
    chk("R8", "word_count", int'(word_count), 6);
    for (int w = 0; w < 6; w++) rd("R8", int'(word_of(5, w)), 0);
    chk("R8", "pointers equal", int'(wr_ptr == rd_ptr), 1);

    // R10: event completes in the load cycle, queue empty before the edge
    @(negedge clk);
    wr_valid = 1'b1; wr_data = word_of(6, 0); wr_last = 1'b1; load_next = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0; load_next = 1'b0;
    chk("R10", "word_count", int'(word_count), 0);
    chk("R10", "has_event", int'(has_event), 1);
    chk("R10", "wr_ptr", int'(wr_ptr), 3);
    chk("R10", "rd_ptr", int'(rd_ptr), 2);

    // R10: event completes in the skip cycle; only the older one is dropped
    put_words(7, 0, 1, 1'b0);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = word_of(7, 1); wr_last = 1'b1; skip = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0; skip = 1'b0;
    chk("R10", "rd_ptr", int'(rd_ptr), 3);
    chk("R10", "wr_ptr", int'(wr_ptr), 0);
    chk("R10", "has_event", int'(has_event), 1);
    cmd(1'b1, 1'b0);
    chk("R10", "word_count", int'(word_count), 2);
    rd("R10", int'(word_of(7, 0)), 0);
    rd("R10", int'(word_of(7, 1)), 0);

    // R10: read request in the load cycle served by the old event
    put_words(8, 0, 2, 1'b1);
    put_words(9, 0, 1, 1'b1);
    cmd(1'b1, 1'b0);
    rd("R10", int'(word_of(8, 0)), 0);
    @(negedge clk);
    rd_req = 1'b1; load_next = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; load_next = 1'b0;
    chk("R10", "overlap data", int'(rd_data), int'(word_of(8, 1)));
    chk("R10", "overlap status", int'(rd_status), 0);
    chk("R10", "word_count", int'(word_count), 1);
    rd("R10", int'(word_of(9, 0)), 0);

    // R9: host pointer overwrite
    ptrs(1, 3);
    chk("R9", "wr_ptr", int'(wr_ptr), 1);
    chk("R9", "rd_ptr", int'(rd_ptr), 3);
    chk("R9", "has_event", int'(has_event), 1);
    chk("R9", "evt_full", int'(evt_full), 0);
    ptrs(2, 3);
    chk("R9", "evt_full", int'(evt_full), 1);
    chk("R9", "wr_ready", int'(wr_ready), 0);
    ptrs(0, 0);
    chk("R9", "has_event", int'(has_event), 0);
    chk("R9", "wr_ready", int'(wr_ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule